// File: doc/BRIEF.md
# Phase-Slip Clock Divider with Pulse Gobbler

This block takes a fast oscillator clock, divides it by a programmable integer, and lets software shift the phase of the divided clock one oscillator period at a time. A slip request line is driven from a register in another clock domain. It is synchronized into the oscillator domain, and its rising edges are detected. Each rising edge removes exactly one oscillator pulse ahead of the divider. The divided clock therefore arrives one oscillator period later than it would have without the request. By issuing repeated requests, a system can walk the output phase until it lines up with an external reference.

The pulse removal has two parts. The divider counter gets a one-cycle hold-off. A latch-based clock gate removes the same pulse cleanly from a gated copy of the oscillator. Because of this, no runt or glitch reaches the divided output.

The divider keeps a nominal 50% duty cycle for even and odd moduli. For odd moduli it adds a half-period extension taken from a falling-edge register. A modulus of 0 or 1 passes the gated oscillator through unchanged. A new modulus is loaded only at an output period boundary.

A select input chooses what goes to the feedback tap: the raw oscillator or the gated clock that feeds the divider.

Top module: `gbl_slip_divider`

## Requirements
- R1: Consider a rising edge of `slip_req` that is first sampled at oscillator edge k. The pulse at oscillator edge k+2 is removed: the divider does not advance on it. The output period that contains this pulse lasts M+1 oscillator cycles instead of M.
- R2: A falling edge of `slip_req` has no effect. Holding it high causes no further slips. Output periods stay at M cycles.
- R3: For a modulus M of 2 or more, with no slip, every output period lasts exactly M oscillator cycles. Each period begins with a rising edge of `clk_out` on a rising oscillator edge.
- R4: For an even M, `clk_out` is high for M/2 oscillator cycles (M half-periods) of each period that has no slip.
- R5: For an odd M, `clk_out` is high for M oscillator half-periods, i.e. M/2 cycles. The extra half cycle comes from a falling-edge register.
- R6: A modulus of 1 passes the gated oscillator to `clk_out`: each period is 1 cycle with the output high for one half-period. A slip then appears as a single 2-cycle period.
- R7: A modulus of 0 behaves the same as a modulus of 1.
- R8: A change of `modulus` in the middle of a period does not alter that period. The new value applies from the next rising edge of `clk_out`.
- R9: With `fb_sel` = 0, `fb_clk` is the raw oscillator. With `fb_sel` = 1, `fb_clk` is the gated clock, which has one fewer rising edge for each slip.
- R10: While `arst_n` is low, `clk_out` is low. The divider counter, the synchronizer and the edge detector are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock |
| arst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| slip_req | input | 1 | Asynchronous slip request; each rising edge removes one oscillator pulse |
| fb_sel | input | 1 | Feedback tap select: 0 raw oscillator, 1 gated clock |
| modulus | input | MOD_W | Divide ratio; 0 and 1 mean bypass |
| clk_out | output | 1 | Divided, phase-slippable clock |
| fb_clk | output | 1 | Feedback tap clock |

## Verification
Faults in the counter or in the modulus register change the length of the very next output period. A fault in the odd-modulus half-cycle path shows up within one period as a high time that is off by half a cycle. A stuck or doubled edge detector leaves out the expected M+1 period, or adds a second one, within the period after the request has crossed the synchronizer. Wrong gating also shows up on the feedback tap: over a fixed window it gives one rising edge too many or too few.

// File: rtl/gbl_pkg.sv
package gbl_pkg;
  localparam int unsigned DEF_MOD_W       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    OUT_BYPASS = 2'd0,
    OUT_EVEN   = 2'd1,
    OUT_ODD    = 2'd2
  } out_mode_t;
endpackage

// File: rtl/gbl_reset_sync.sv
module gbl_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[STAGES-1];
endmodule

// File: rtl/gbl_edge_sync.sv
module gbl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic slip_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              prev_d;

  // synchronizer stages, one flop per stage
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stage_d;
    if (i == 0) begin : g_first
      assign stage_d = req_async;
    end else begin : g_rest
      assign stage_d = chain_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= stage_d;
    end
  end

  always_comb begin
    prev_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign slip_o = chain_q[STAGES-1] & ~prev_q;

  // R1: one request edge yields a single-cycle slip strobe
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !slip_o);
endmodule

// File: rtl/gbl_icg.sv
module gbl_icg (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // enable captured only while the clock is low, so the gate never chops a pulse
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/gbl_half_div.sv
module gbl_half_div
  import gbl_pkg::*;
#(
  parameter int unsigned MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             gclk,
  output logic             div_o
);
  localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

  logic [MOD_W-1:0] cnt_q, cnt_d;
  logic [MOD_W-1:0] mod_q, mod_d;
  logic [MOD_W-1:0] mod_eff;
  logic             rise_q, rise_d;
  logic             fall_q;
  logic             wrap;
  out_mode_t        mode;

  always_comb begin
    mod_eff = (mod_q < MOD_W'(2)) ? ONE : mod_q;
    wrap    = (cnt_q == mod_eff - ONE);
    cnt_d   = cnt_q;
    mod_d   = mod_q;
    rise_d  = rise_q;
    if (en) begin
      if (wrap) begin
        cnt_d = '0;
        mod_d = mod_i;
      end else begin
        cnt_d = cnt_q + ONE;
      end
      rise_d = (cnt_d < (mod_d >> 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mod_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mod_q  <= mod_d;
      rise_q <= rise_d;
    end
  end

  // half-period delayed copy for odd moduli
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  always_comb begin
    if (mod_q < MOD_W'(2)) mode = OUT_BYPASS;
    else if (mod_q[0])     mode = OUT_ODD;
    else                   mode = OUT_EVEN;
  end

  always_comb begin
    unique case (mode)
      OUT_BYPASS: div_o = gclk;
      OUT_ODD:    div_o = rise_q | fall_q;
      default:    div_o = rise_q;
    endcase
  end

  // R3: counter stays inside the active modulus
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < mod_eff);

  // R1: a removed pulse freezes counter and phase for that cycle
  a_r1_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(rise_q)));

  // R8: modulus register moves only on a period boundary
  a_r8_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != $past(mod_q)) |-> $past(en && wrap));

  // R2: without a slip the counter always advances
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/gbl_slip_divider.sv
module gbl_slip_divider
  import gbl_pkg::*;
#(
  parameter int unsigned MOD_W       = DEF_MOD_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             vco_clk,
  input  logic             arst_n,
  input  logic             slip_req,
  input  logic             fb_sel,
  input  logic [MOD_W-1:0] modulus,
  output logic             clk_out,
  output logic             fb_clk
);
  logic rst_n_s;
  logic slip;
  logic adv_en;
  logic clk_gated;
  logic div_out;

  gbl_reset_sync #(.STAGES(2)) u_rst (
    .clk     (vco_clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  gbl_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (vco_clk),
    .rst_n     (rst_n_s),
    .req_async (slip_req),
    .slip_o    (slip)
  );

  assign adv_en = ~slip;

  gbl_icg u_icg (
    .clk  (vco_clk),
    .en   (adv_en),
    .gclk (clk_gated)
  );

  gbl_half_div #(.MOD_W(MOD_W)) u_div (
    .clk   (vco_clk),
    .rst_n (rst_n_s),
    .en    (adv_en),
    .mod_i (modulus),
    .gclk  (clk_gated),
    .div_o (div_out)
  );

  assign clk_out = rst_n_s & div_out;
  assign fb_clk  = fb_sel ? clk_gated : vco_clk;
endmodule

// File: tb/gbl_slip_divider_tb.sv
`timescale 1ns/1ps
module gbl_slip_divider_tb;
  localparam int MOD_W = 8;

  logic             vco_clk;
  logic             arst_n;
  logic             slip_req;
  logic             fb_sel;
  logic [MOD_W-1:0] modulus;
  logic             clk_out;
  logic             fb_clk;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    int    len;
    int    hh;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  gbl_slip_divider #(.MOD_W(MOD_W)) u_dut (
    .vco_clk (vco_clk),
    .arst_n  (arst_n),
    .slip_req(slip_req),
    .fb_sel  (fb_sel),
    .modulus (modulus),
    .clk_out (clk_out),
    .fb_clk  (fb_clk)
  );

  initial vco_clk = 1'b0;
  always #5 vco_clk = ~vco_clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: measure each finished period and compare with the scoreboard
  realtime t_last, t_fall, t_now;
  bit      have_last = 0;
  exp_t    cur;
  int      per, hh;

  always @(negedge clk_out) t_fall = $realtime;

  always @(posedge clk_out) begin
    t_now = $realtime;
    if (have_last && exp_q.size() != 0) begin
      cur = exp_q.pop_front();
      per = int'((t_now - t_last) / 10.0);
      check(per == cur.len, {cur.tag, " period"}, per, cur.len);
      if (cur.hh >= 0) begin
        hh = int'((t_fall - t_last) / 5.0);
        check(hh == cur.hh, {cur.tag, " high half-cycles"}, hh, cur.hh);
      end
    end
    have_last = 1;
    t_last    = t_now;
  end

  int fb_cnt = 0;
  always @(posedge fb_clk) fb_cnt++;

  task automatic push(input int len, input int hhv, input string tag);
    exp_t e;
    e.len = len; e.hh = hhv; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic sync_rise(input int n);
    repeat (n) @(posedge clk_out);
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge vco_clk);
  endtask

  task automatic fb_window(input bit sel, input bit do_slip, input int expv, input string tag);
    @(negedge vco_clk);
    fb_sel = sel;
    repeat (2) @(negedge vco_clk);
    fb_cnt = 0;
    slip_req = do_slip;
    repeat (20) @(negedge vco_clk);
    check(fb_cnt == expv, tag, fb_cnt, expv);
    slip_req = 1'b0;
    repeat (6) @(negedge vco_clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    arst_n   = 1'b1;
    slip_req = 1'b0;
    fb_sel   = 1'b0;
    modulus  = 8'd6;
    #1 arst_n = 1'b0;
    // R10: output held low during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge vco_clk);
      check(clk_out == 1'b0, "R10 reset low", int'(clk_out), 0);
    end
    @(negedge vco_clk) arst_n = 1'b1;
    sync_rise(4);

    // R3/R4: even modulus
    for (int i = 0; i < 4; i++) push(6, 6, "R3/R4 even");
    drain();

    // R1: slip on even modulus, then R2 hold high
    sync_rise(1);
    slip_req = 1'b1;
    push(7, -1, "R1 slip even");
    push(6, 6, "R2 held high");
    push(6, 6, "R2 held high");
    drain();
    slip_req = 1'b0;
    push(6, 6, "R2 falling edge");
    push(6, 6, "R2 falling edge");
    push(6, 6, "R2 falling edge");
    drain();

    // R8 change to odd, R5 odd duty
    sync_rise(1);
    modulus = 8'd7;
    push(6, 6, "R8 old modulus kept");
    for (int i = 0; i < 3; i++) push(7, 7, "R5 odd duty");
    drain();

    // R1 slip on odd modulus
    sync_rise(1);
    slip_req = 1'b1;
    push(8, -1, "R1 slip odd");
    push(7, 7, "R5 after slip");
    drain();
    slip_req = 1'b0;

    // R8 to 9, two slips in separate periods
    sync_rise(1);
    modulus = 8'd9;
    push(7, 7, "R8 old modulus kept");
    push(9, 9, "R5 odd 9");
    push(9, 9, "R5 odd 9");
    drain();
    sync_rise(1);
    slip_req = 1'b1;
    push(10, -1, "R1 first slip");
    drain();
    slip_req = 1'b0;
    sync_rise(1);
    slip_req = 1'b1;
    push(10, -1, "R1 second slip");
    push(9, 9, "R3 after slip");
    drain();
    slip_req = 1'b0;

    // R6 bypass
    sync_rise(1);
    modulus = 8'd1;
    push(9, 9, "R8 old modulus kept");
    drain();
    sync_rise(3);
    for (int i = 0; i < 3; i++) push(1, 1, "R6 bypass");
    drain();
    sync_rise(1);
    slip_req = 1'b1;
    push(1, 1, "R6 bypass");
    push(1, 1, "R6 bypass");
    push(2, 1, "R6 bypass slip");
    push(1, 1, "R6 bypass");
    drain();
    slip_req = 1'b0;

    // R7 modulus zero
    sync_rise(3);
    modulus = 8'd0;
    for (int i = 0; i < 4; i++) push(1, 1, "R7 zero modulus");
    drain();

    // R9 feedback tap
    modulus = 8'd6;
    sync_rise(4);
    fb_window(1'b0, 1'b1, 20, "R9 raw tap ignores slip");
    fb_window(1'b1, 1'b0, 20, "R9 gated tap no slip");
    fb_window(1'b1, 1'b1, 19, "R9 gated tap slip");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule